// File: doc/BRIEF.md
# Byte-Stream Block Sequencer

This block sits between a byte-wide source and a hash compression engine. A source hands over a message that has already been padded, one byte per accepted transfer. The block packs consecutive bytes into a wide block register. When the block is full, or when the final byte of the message arrives, it hands the block to the engine and stops taking input until the engine reports completion.

Each engine result becomes the chaining state for the next block of the same message. The first block of a message uses a fixed initial value instead, and the block tells the engine which case applies. When the block holding the final byte has been compressed, the result is latched as the message digest and a done flag is raised. If the final byte does not close a block exactly, the message is marked as malformed.

Top module: `msg_block_sequencer`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `done`, `malformed` and `eng_start` are 0.
- R2: While no message is being loaded (after reset, or while `done` is high), an offered byte is accepted only when `in_first` is 1. Other offered bytes are dropped and change neither the outputs nor the later digest.
- R3: The first byte of each block lands in `eng_block[BLK_W-1 -: 8]`, and each following byte lands in the next lower byte lane. Lanes not written in the current block read as zero.
- R4: In the cycle after the byte that fills the last lane is accepted, `eng_start` is high for exactly one cycle and `in_ready` is low.
- R5: While a block is with the engine, `in_ready` stays low and offered bytes are ignored. `eng_ready` is not acted on in the cycle in which `eng_start` is high.
- R6: For the first block of a message, `eng_first_run` is 1 and `eng_chain` equals the initial value. For every later block, `eng_first_run` is 0 and `eng_chain` equals the engine's previous `eng_hash`.
- R7: When the engine finishes the block that held the `in_last` byte, `done` goes to 1 in the next cycle, `digest` equals that `eng_hash`, and `in_ready` returns to 1. `done` and `digest` hold until a new first byte is accepted.
- R8: When the engine finishes a block without the last byte, `in_ready` returns to 1, `done` stays 0 and the next byte fills the top lane of a fresh block.
- R9: A byte with `in_last` that is not the final lane of its block sends the partly filled block to the engine at once, and `malformed` goes to 1. `malformed` clears when the next message's first byte is accepted.
- R10: A byte with `in_first` accepted in the middle of loading abandons the partial block and starts a new message at the top lane, with the initial chaining value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | BYTE_W | Message byte |
| in_valid | input | 1 | Byte offered this cycle |
| in_first | input | 1 | Byte is the first of a message |
| in_last | input | 1 | Byte is the final padded byte of the message |
| in_ready | output | 1 | A byte may be accepted |
| done | output | 1 | Digest of the whole message is valid |
| malformed | output | 1 | Last byte did not close a block |
| digest | output | STATE_W | Final message digest |
| eng_block | output | BLOCK_BYTES*BYTE_W | Assembled block for the engine |
| eng_start | output | 1 | One-cycle request to compress `eng_block` |
| eng_first_run | output | 1 | Engine uses its initial value |
| eng_chain | output | STATE_W | Chaining state for this block |
| eng_ready | input | 1 | Engine has finished the current block |
| eng_hash | input | STATE_W | Engine result |

## Verification
The bench builds the block with four-byte blocks and a 32-bit state. With these settings a three-block chain, a malformed length partway through a block, a restart in mid-load and a new message started from the done state each take only a few dozen cycles. The engine is replaced by a behavioural stand-in with a fixed latency and a simple mixing function. It holds its ready level high after each result, so a stale ready is present when the next block starts. Each digest is also recomputed straight from the byte list, with no reference to timing.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_HASH = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_lane_buffer.sv
// Byte lanes of the block register; lane 0 is the most significant byte.
module seq_lane_buffer #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 64,
  parameter int IDX_W  = 7,
  localparam int BLK_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              clear_rest,
  input  logic [IDX_W-1:0]  lane_idx,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BLK_W-1:0]  block
);
  logic [BYTE_W-1:0] lane_q [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q[i] <= '0;
      end else if (wr_en) begin
        if (lane_idx == IDX_W'(i)) lane_q[i] <= wr_byte;
        else if (clear_rest)       lane_q[i] <= '0;
      end
    end
    assign block[BLK_W-1-i*BYTE_W -: BYTE_W] = lane_q[i];
  end
endmodule

// File: rtl/seq_chain_store.sv
// Chaining state, first-block flag and final digest.
module seq_chain_store #(
  parameter int STATE_W = 256,
  parameter logic [STATE_W-1:0] IV = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msg_begin,
  input  logic               blk_done,
  input  logic               msg_end,
  input  logic [STATE_W-1:0] eng_hash,
  output logic [STATE_W-1:0] chain,
  output logic               first_run,
  output logic [STATE_W-1:0] digest
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chain     <= IV;
      first_run <= 1'b1;
      digest    <= '0;
    end else if (msg_begin) begin
      chain     <= IV;
      first_run <= 1'b1;
    end else if (blk_done) begin
      chain     <= eng_hash;
      first_run <= 1'b0;
      if (msg_end) digest <= eng_hash;
    end
  end

  // R6: a first block always carries the initial value
  p_first_uses_iv_r6: assert property (@(posedge clk) disable iff (rst)
    first_run |-> (chain == IV));
endmodule

// File: rtl/seq_ctrl.sv
// Load / hash / done sequencing and input throttling.
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int NBYTES = 64,
  parameter int CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic             eng_ready,
  output logic             in_ready,
  output logic             eng_start,
  output logic             done,
  output logic             err,
  output logic             acc,
  output logic             acc_first,
  output logic             blk_begin,
  output logic [CNT_W-1:0] lane_idx,
  output logic             blk_done,
  output logic             msg_end
);
  seq_state_e       st;
  logic [CNT_W-1:0] cnt, nxt;
  logic             last_seen, full, close, short_last;

  assign acc        = in_valid & in_ready & (in_first | (st == ST_LOAD));
  assign acc_first  = acc & in_first;
  assign lane_idx   = in_first ? '0 : cnt;
  assign blk_begin  = in_first | (cnt == '0);
  assign nxt        = lane_idx + 1'b1;
  assign full       = (nxt == CNT_W'(NBYTES));
  assign close      = acc & (full | in_last);
  assign short_last = close & in_last & ~full;
  assign blk_done   = (st == ST_HASH) & ~eng_start & eng_ready;
  assign msg_end    = blk_done & last_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      in_ready  <= 1'b1;
      eng_start <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      last_seen <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      if (acc) begin
        cnt <= close ? '0 : nxt;
        st  <= close ? ST_HASH : ST_LOAD;
        if (close) begin
          in_ready  <= 1'b0;
          eng_start <= 1'b1;
          last_seen <= in_last;
        end
        if (acc_first) begin
          done <= 1'b0;
          err  <= short_last;
        end else if (short_last) begin
          err <= 1'b1;
        end
      end else if (blk_done) begin
        in_ready <= 1'b1;
        st       <= last_seen ? ST_DONE : ST_LOAD;
        if (last_seen) done <= 1'b1;
      end
    end
  end

  // R4: engine request lasts one cycle
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  // R5: no input accepted while the engine owns the block
  p_hash_blocks_input_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HASH) |-> !in_ready);
  // R7: done holds until a new message starts
  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !acc_first) |=> done);
  // R9: malformed flag only seen with a message in flight or finished
  p_err_scope_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> (done || st == ST_HASH));
endmodule

// File: rtl/msg_block_sequencer.sv
module msg_block_sequencer #(
  parameter int BYTE_W      = 8,
  parameter int BLOCK_BYTES = 64,
  parameter int STATE_W     = 256,
  parameter logic [STATE_W-1:0] IV =
    256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19,
  localparam int BLK_W = BYTE_W * BLOCK_BYTES,
  localparam int CNT_W = $clog2(BLOCK_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BYTE_W-1:0]  in_byte,
  input  logic               in_valid,
  input  logic               in_first,
  input  logic               in_last,
  output logic               in_ready,
  output logic               done,
  output logic               malformed,
  output logic [STATE_W-1:0] digest,
  output logic [BLK_W-1:0]   eng_block,
  output logic               eng_start,
  output logic               eng_first_run,
  output logic [STATE_W-1:0] eng_chain,
  input  logic               eng_ready,
  input  logic [STATE_W-1:0] eng_hash
);
  logic             acc, acc_first, blk_begin, blk_done, msg_end;
  logic [CNT_W-1:0] lane_idx;

  seq_ctrl #(.NBYTES(BLOCK_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .eng_ready(eng_ready), .in_ready(in_ready),
    .eng_start(eng_start), .done(done), .err(malformed), .acc(acc),
    .acc_first(acc_first), .blk_begin(blk_begin), .lane_idx(lane_idx),
    .blk_done(blk_done), .msg_end(msg_end)
  );

  seq_lane_buffer #(.BYTE_W(BYTE_W), .NBYTES(BLOCK_BYTES), .IDX_W(CNT_W)) u_lanes (
    .clk(clk), .rst(rst), .wr_en(acc), .clear_rest(blk_begin),
    .lane_idx(lane_idx), .wr_byte(in_byte), .block(eng_block)
  );

  seq_chain_store #(.STATE_W(STATE_W), .IV(IV)) u_chain (
    .clk(clk), .rst(rst), .msg_begin(acc_first), .blk_done(blk_done),
    .msg_end(msg_end), .eng_hash(eng_hash), .chain(eng_chain),
    .first_run(eng_first_run), .digest(digest)
  );

  // R7: digest is frozen while done stays up
  p_digest_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !acc_first) |=> $stable(digest));
  // R5: bytes offered during hashing never reach the block
  p_block_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(eng_block));
endmodule

// File: tb/test_msg_block_sequencer.sv
module test_msg_block_sequencer;
  localparam int NB = 4;
  localparam int SW = 32;
  localparam int BW = NB * 8;
  localparam logic [SW-1:0] IVB = 32'h6a09e667;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] in_byte = '0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic in_ready, done, malformed, eng_start, eng_first_run;
  logic [SW-1:0] digest, eng_chain;
  logic [BW-1:0] eng_block;
  logic eng_ready;
  logic [SW-1:0] eng_hash;

  always #2 clk = ~clk;

  msg_block_sequencer #(.BYTE_W(8), .BLOCK_BYTES(NB), .STATE_W(SW), .IV(IVB))
    i_msg_block_sequencer (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
    .in_first(in_first), .in_last(in_last), .in_ready(in_ready), .done(done),
    .malformed(malformed), .digest(digest), .eng_block(eng_block),
    .eng_start(eng_start), .eng_first_run(eng_first_run), .eng_chain(eng_chain),
    .eng_ready(eng_ready), .eng_hash(eng_hash)
  );

  function automatic logic [SW-1:0] mix(input logic [SW-1:0] c, input logic [BW-1:0] b);
    return ({c[26:0], c[31:27]} ^ b) + 32'h9e3779b9;
  endfunction

  // stand-in engine: ready level stays high until the next start
  logic [BW-1:0] cap_b;
  logic [SW-1:0] cap_c;
  int tmr;
  always @(posedge clk) begin
    if (rst) begin
      eng_ready <= 1'b0; eng_hash <= '0; tmr <= 0;
    end else if (eng_start) begin
      eng_ready <= 1'b0; cap_b <= eng_block; cap_c <= eng_chain; tmr <= LAT;
    end else if (tmr > 0) begin
      tmr <= tmr - 1;
      if (tmr == 1) begin eng_ready <= 1'b1; eng_hash <= mix(cap_c, cap_b); end
    end
  end

  // behavioural reference, stepped on every rising edge
  int m_st, m_cnt;
  bit m_rdy, m_done, m_err, m_start, m_fr, m_last;
  logic [BW-1:0] m_blk;
  logic [SW-1:0] m_chain, m_dig;
  always @(posedge clk) begin
    bit acc, evt;
    logic [SW-1:0] h;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_rdy = 1; m_done = 0; m_err = 0; m_start = 0;
      m_fr = 1; m_last = 0; m_blk = '0; m_chain = IVB; m_dig = '0;
    end else begin
      acc = in_valid && m_rdy && (in_first || m_st == 1);
      evt = (m_st == 2) && !m_start && eng_ready;
      h = eng_hash;
      m_start = 0;
      if (acc) begin
        if (in_first) begin m_cnt = 0; m_chain = IVB; m_fr = 1; m_err = 0; m_done = 0; end
        if (m_cnt == 0) m_blk = '0;
        m_blk[BW-1-8*m_cnt -: 8] = in_byte;
        m_cnt++;
        m_st = 1;
        if (m_cnt == NB || in_last) begin
          if (in_last && m_cnt != NB) m_err = 1;
          m_last = in_last; m_cnt = 0; m_st = 2; m_rdy = 0; m_start = 1;
        end
      end else if (evt) begin
        m_chain = h; m_fr = 0; m_rdy = 1;
        if (m_last) begin m_done = 1; m_dig = h; m_st = 3; end
        else m_st = 1;
      end
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(in_ready == m_rdy, "R4/R5/R8 in_ready", 64'(in_ready), 64'(m_rdy));
      chk(done == m_done, "R7/R8 done", 64'(done), 64'(m_done));
      chk(malformed == m_err, "R9 malformed", 64'(malformed), 64'(m_err));
      chk(eng_start == m_start, "R4 eng_start", 64'(eng_start), 64'(m_start));
      if (m_start) begin
        chk(eng_block == m_blk, "R3 eng_block", 64'(eng_block), 64'(m_blk));
        chk(eng_first_run == m_fr, "R6 first_run", 64'(eng_first_run), 64'(m_fr));
        chk(eng_chain == m_chain, "R6 eng_chain", 64'(eng_chain), 64'(m_chain));
      end
      if (m_done) chk(digest == m_dig, "R7 digest", 64'(digest), 64'(m_dig));
    end
  end

  function automatic logic [SW-1:0] ref_digest(input logic [7:0] q[$]);
    logic [SW-1:0] c = IVB;
    logic [BW-1:0] b = '0;
    int n = 0;
    foreach (q[i]) begin
      b[BW-1-8*n -: 8] = q[i];
      n++;
      if (n == NB) begin c = mix(c, b); b = '0; n = 0; end
    end
    if (n != 0) c = mix(c, b);
    return c;
  endfunction

  task automatic send(input logic [7:0] b, input bit f, input bit l);
    in_byte = b; in_first = f; in_last = l; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic poke(input logic [7:0] b);
    in_byte = b; in_first = 1'b0; in_last = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_msg(input logic [7:0] q[$], input bit exp_err, input string tag);
    foreach (q[i]) begin
      send(q[i], i == 0, i == q.size() - 1);
      if (i == NB - 1) poke(8'hee);   // R5: offered while hashing
    end
    while (!done) @(negedge clk);
    chk(digest == ref_digest(q), {tag, " R7 digest vs byte list"}, 64'(digest), 64'(ref_digest(q)));
    chk(malformed == exp_err, {tag, " R9 flag"}, 64'(malformed), 64'(exp_err));
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog done actual=0 expected=1");
    report();
  end

  initial begin
    logic [7:0] qa[$], qb[$], qc[$], qd[$];
    logic [SW-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk(in_ready && !done && !malformed && !eng_start, "R1 reset state",
        {60'd0, in_ready, done, malformed, eng_start}, 64'h8);
    // R2: byte without first marker while idle
    poke(8'h55);
    chk(in_ready == 1'b1, "R2 idle drop", 64'(in_ready), 64'h1);
    qa = '{8'h11, 8'h22, 8'h33, 8'h44};
    run_msg(qa, 1'b0, "R3 single block");
    held = digest;
    poke(8'h77);                        // R2 while done
    chk(done && digest == held, "R2 done drop", 64'(digest), 64'(held));
    qb = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0a, 8'h0b, 8'h0c};
    run_msg(qb, 1'b0, "R6 R8 three blocks");
    qc = '{8'ha0, 8'ha1, 8'ha2, 8'ha3, 8'ha4, 8'ha5};
    run_msg(qc, 1'b1, "R9 short last");
    // R10: abandon a partial block
    send(8'hc1, 1'b1, 1'b0);
    send(8'hc2, 1'b0, 1'b0);
    qd = '{8'hd1, 8'hd2, 8'hd3, 8'hd4, 8'hd5};
    run_msg(qd, 1'b1, "R10 restart");
    qd = '{8'h5a};
    run_msg(qd, 1'b1, "R9 lone last");
    qa = '{8'hf0, 8'hf1, 8'hf2, 8'hf3, 8'hf4, 8'hf5, 8'hf6, 8'hf7};
    run_msg(qa, 1'b0, "R9 clear");
    repeat (3) @(negedge clk);
    report();
  end
endmodule